// File: doc/BRIEF.md
# Coprocessor Access Permission Checker

This block holds a 32-bit system control register that grants or withholds access to the floating-point and vector coprocessors. It also decides, combinationally and for every instruction offered to it, whether that instruction must raise an undefined-instruction exception. Software reads and writes the register through a coprocessor-style system-register port. An access is selected by a fixed encoding tuple and is qualified by the current exception level.

The check takes four inputs: the exception level, the instruction class (floating-point, vector without floating-point, or other), a flag that says whether floating-point and vector hardware is present, and a two-bit permission mask that applies in non-secure state. Only the low coprocessor field sets the permission that is enforced. The high field is stored and read back, but it never changes an outcome. A separate top bit blocks the vector instructions that are not floating-point.

Top module: `cop_access_guard`

## Requirements
- R1: After reset both access fields are 00 and the vector-disable bit is 0, so a read returns 0x00000000.
- R2: Read layout: the disable bit is bit 31, the high field is bits 23:22 and the low field is bits 21:20. Every other bit reads 0, whatever was written to it.
- R3: An access is selected only when coproc=15, opc1=0, CRn=1, CRm=0 and opc2=2. Any other tuple leaves sys_hit_o low, returns 0 and changes no state.
- R4: A selected write at EL1, EL2 or EL3 is visible from the next clock edge on. A selected access at EL0 raises sys_undef_o, returns 0 and writes nothing.
- R5: Instruction class codes are 01 for floating-point, 10 for vector without floating-point, and 00 or 11 for other. An instruction of class other is never flagged.
- R6: The enforced permission comes from the low field. 11 allows access. 01 allows access at every level except EL0. 00 and 10 deny access. The high field has no effect on enforcement but reads back as written.
- R7: When the disable bit is 1, vector instructions that are not floating-point are undefined. Floating-point instructions are unaffected by this bit.
- R8: No instruction issued at EL2 is flagged by the check.
- R9: In non-secure state (nonsec_i=1), ns_mask_i bit 0 governs the low field and bit 1 governs the high field. A cleared bit makes its field read 00, ignore writes, and, for the low field, enforce as denied. In secure state the mask is ignored.
- R10: With impl_i=0, reads return 0, writes are ignored, and floating-point and vector instructions are undefined everywhere except at EL2.
- R11: With insn_valid_i low, insn_undef_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| el_i | input | 2 | Current exception level (0..3) |
| nonsec_i | input | 1 | 1 when executing in non-secure state |
| ns_mask_i | input | 2 | Non-secure permission mask, bit 0 low field, bit 1 high field |
| impl_i | input | 1 | Floating-point and vector hardware present |
| sys_req_i | input | 1 | System-register access request |
| sys_we_i | input | 1 | 1 write, 0 read |
| sys_coproc_i | input | 4 | Access tuple: coprocessor number |
| sys_opc1_i | input | 3 | Access tuple: opc1 |
| sys_crn_i | input | 4 | Access tuple: CRn |
| sys_crm_i | input | 4 | Access tuple: CRm |
| sys_opc2_i | input | 3 | Access tuple: opc2 |
| sys_wdata_i | input | 32 | Write data |
| sys_hit_o | output | 1 | The request selects this register |
| sys_undef_o | output | 1 | Selected access attempted from EL0 |
| sys_rdata_o | output | 32 | Read data, 0 when no qualified read is in progress |
| insn_valid_i | input | 1 | Instruction offered for checking |
| insn_class_i | input | 2 | Instruction class code |
| insn_undef_o | output | 1 | Instruction must be undefined |

## Verification
The bench programs the two fields with values that disagree. A design that enforced the high field, or the higher of the two fields, would then give the wrong undefined flag in the permission scan, even though the high field reads back correctly. The bench checks the reserved code 10, the EL0-only trap of code 01, and the EL2 exemption at every field value; a slip in the permission decode shows up in one of those cells. Masked non-secure writes, and feature absence followed by restoration, are used to find a design that lets a blocked write through or that clears storage it should only hide.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int DATA_W     = 32;
  localparam int FIELD_W    = 2;
  localparam int NUM_FIELDS = 2;
  localparam int FIELD_LSB  = 20;
  localparam int DIS_BIT    = 31;

  typedef enum logic [1:0] {EL0 = 2'd0, EL1 = 2'd1, EL2 = 2'd2, EL3 = 2'd3} el_e;
  typedef enum logic [1:0] {CLS_OTHER = 2'd0, CLS_FP = 2'd1, CLS_VEC = 2'd2, CLS_OTHER2 = 2'd3} cls_e;
  typedef enum logic [1:0] {PERM_NONE = 2'd0, PERM_PRIV = 2'd1, PERM_RSVD = 2'd2, PERM_FULL = 2'd3} perm_e;
endpackage

// File: rtl/cpg_sysreg_decode.sv
module cpg_sysreg_decode
  import cpg_pkg::*;
#(
  parameter logic [3:0] SEL_COPROC = 4'd15,
  parameter logic [2:0] SEL_OPC1   = 3'd0,
  parameter logic [3:0] SEL_CRN    = 4'd1,
  parameter logic [3:0] SEL_CRM    = 4'd0,
  parameter logic [2:0] SEL_OPC2   = 3'd2
) (
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] el_i,
  input  logic [3:0] coproc_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output logic       hit_o,
  output logic       undef_o,
  output logic       wr_en_o,
  output logic       rd_en_o
);
  logic tuple_match, priv;

  assign tuple_match = (coproc_i == SEL_COPROC) && (opc1_i == SEL_OPC1) &&
                       (crn_i == SEL_CRN) && (crm_i == SEL_CRM) && (opc2_i == SEL_OPC2);
  assign priv    = (el_e'(el_i) != EL0);
  assign hit_o   = req_i && tuple_match;
  assign undef_o = hit_o && !priv;
  assign wr_en_o = hit_o && priv && we_i;
  assign rd_en_o = hit_o && priv && !we_i;
endmodule

// File: rtl/cpg_ctrl_reg.sv
module cpg_ctrl_reg
  import cpg_pkg::*;
#(
  parameter int NF  = NUM_FIELDS,
  parameter int FW  = FIELD_W,
  parameter int LSB = FIELD_LSB,
  parameter int DW  = DATA_W,
  parameter int DB  = DIS_BIT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  nonsec_i,
  input  logic                  impl_i,
  input  logic [NF-1:0]         ns_mask_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NF-1:0][FW-1:0] field_o,
  output logic                  dis_o,
  output logic [DW-1:0]         view_o
);
  logic [FW-1:0] field_q [NF];
  logic [FW-1:0] vis     [NF];
  logic          dis_q;

  for (genvar i = 0; i < NF; i++) begin : g_field
    logic open_i;
    // non-secure software sees and changes a field only when its mask bit is set
    assign open_i = impl_i && (!nonsec_i || ns_mask_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                field_q[i] <= '0;
      else if (wr_en_i && open_i) field_q[i] <= wdata_i[LSB+i*FW +: FW];
    end

    assign vis[i]     = open_i ? field_q[i] : '0;
    assign field_o[i] = field_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dis_q <= 1'b0;
    else if (wr_en_i && impl_i) dis_q <= wdata_i[DB];
  end

  assign dis_o = dis_q;

  always_comb begin
    view_o     = '0;
    view_o[DB] = impl_i && dis_q;
    for (int i = 0; i < NF; i++) view_o[LSB+i*FW +: FW] = vis[i];
  end
endmodule

// File: rtl/cpg_perm_eval.sv
module cpg_perm_eval
  import cpg_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic          valid_i,
  input  logic [1:0]    el_i,
  input  logic [1:0]    class_i,
  input  logic          impl_i,
  input  logic          nonsec_i,
  input  logic          lo_mask_i,
  input  logic [FW-1:0] lo_field_i,
  input  logic          dis_i,
  output logic          undef_o
);
  perm_e eff;
  logic  allow, is_fp, is_vec, exempt;

  // only the low field is enforced; masked or absent hardware enforces as denied
  assign eff = (impl_i && (!nonsec_i || lo_mask_i)) ? perm_e'(lo_field_i) : PERM_NONE;

  always_comb begin
    unique case (eff)
      PERM_FULL: allow = 1'b1;
      PERM_PRIV: allow = (el_e'(el_i) != EL0);
      default:   allow = 1'b0;
    endcase
  end

  assign is_fp   = (cls_e'(class_i) == CLS_FP);
  assign is_vec  = (cls_e'(class_i) == CLS_VEC);
  assign exempt  = (el_e'(el_i) == EL2);
  assign undef_o = valid_i && (is_fp || is_vec) && !exempt &&
                   (!allow || (is_vec && dis_i));
endmodule

// File: rtl/cop_access_guard.sv
module cop_access_guard
  import cpg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  el_i,
  input  logic        nonsec_i,
  input  logic [1:0]  ns_mask_i,
  input  logic        impl_i,
  input  logic        sys_req_i,
  input  logic        sys_we_i,
  input  logic [3:0]  sys_coproc_i,
  input  logic [2:0]  sys_opc1_i,
  input  logic [3:0]  sys_crn_i,
  input  logic [3:0]  sys_crm_i,
  input  logic [2:0]  sys_opc2_i,
  input  logic [31:0] sys_wdata_i,
  output logic        sys_hit_o,
  output logic        sys_undef_o,
  output logic [31:0] sys_rdata_o,
  input  logic        insn_valid_i,
  input  logic [1:0]  insn_class_i,
  output logic        insn_undef_o
);
  logic wr_en, rd_en, dis_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_q;
  logic [DATA_W-1:0] view;

  cpg_sysreg_decode u_dec (
    .req_i   (sys_req_i),
    .we_i    (sys_we_i),
    .el_i    (el_i),
    .coproc_i(sys_coproc_i),
    .opc1_i  (sys_opc1_i),
    .crn_i   (sys_crn_i),
    .crm_i   (sys_crm_i),
    .opc2_i  (sys_opc2_i),
    .hit_o   (sys_hit_o),
    .undef_o (sys_undef_o),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en)
  );

  cpg_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .nonsec_i (nonsec_i),
    .impl_i   (impl_i),
    .ns_mask_i(ns_mask_i),
    .wdata_i  (sys_wdata_i),
    .field_o  (field_q),
    .dis_o    (dis_q),
    .view_o   (view)
  );

  cpg_perm_eval u_eval (
    .valid_i   (insn_valid_i),
    .el_i      (el_i),
    .class_i   (insn_class_i),
    .impl_i    (impl_i),
    .nonsec_i  (nonsec_i),
    .lo_mask_i (ns_mask_i[0]),
    .lo_field_i(field_q[0]),
    .dis_i     (dis_q),
    .undef_o   (insn_undef_o)
  );

  assign sys_rdata_o = rd_en ? view : '0;
endmodule

// File: rtl/cop_access_guard_chk.sv
module cop_access_guard_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  el_i,
  input logic        nonsec_i,
  input logic        impl_i,
  input logic        sys_we_i,
  input logic [31:0] sys_wdata_i,
  input logic        sys_hit_o,
  input logic        sys_undef_o,
  input logic [31:0] sys_rdata_o,
  input logic        insn_valid_i,
  input logic [1:0]  insn_class_i,
  input logic        insn_undef_o,
  input logic [1:0]  lo_field
);
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rdata_o[30:24] == '0) && (sys_rdata_o[19:0] == '0));

  a_r4_el0_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_hit_o && el_i == 2'd0) |-> (sys_undef_o && sys_rdata_o == '0));

  a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_hit_o && sys_we_i && el_i != 2'd0 && impl_i && !nonsec_i)
      |=> (lo_field == $past(sys_wdata_i[21:20])));

  a_r5_other_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_class_i == 2'd0 || insn_class_i == 2'd3) |-> !insn_undef_o);

  a_r8_el2_exempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_i == 2'd2) |-> !insn_undef_o);

  a_r10_absent_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !impl_i |-> (sys_rdata_o == '0));

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |-> !insn_undef_o);
endmodule

bind cop_access_guard cop_access_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .el_i        (el_i),
  .nonsec_i    (nonsec_i),
  .impl_i      (impl_i),
  .sys_we_i    (sys_we_i),
  .sys_wdata_i (sys_wdata_i),
  .sys_hit_o   (sys_hit_o),
  .sys_undef_o (sys_undef_o),
  .sys_rdata_o (sys_rdata_o),
  .insn_valid_i(insn_valid_i),
  .insn_class_i(insn_class_i),
  .insn_undef_o(insn_undef_o),
  .lo_field    (field_q[0])
);

// File: tb/cop_access_guard_tb_top.sv
module cop_access_guard_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  el_i = 2'd1;
  logic        nonsec_i = 1'b0;
  logic [1:0]  ns_mask_i = 2'b11;
  logic        impl_i = 1'b1;
  logic        sys_req_i = 1'b0;
  logic        sys_we_i = 1'b0;
  logic [3:0]  sys_coproc_i = 4'd15;
  logic [2:0]  sys_opc1_i = 3'd0;
  logic [3:0]  sys_crn_i = 4'd1;
  logic [3:0]  sys_crm_i = 4'd0;
  logic [2:0]  sys_opc2_i = 3'd2;
  logic [31:0] sys_wdata_i = '0;
  logic        sys_hit_o, sys_undef_o, insn_undef_o;
  logic [31:0] sys_rdata_o;
  logic        insn_valid_i = 1'b0;
  logic [1:0]  insn_class_i = 2'd0;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_lo = '0, m_hi = '0;
  logic       m_dis = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cop_access_guard dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_view();
    logic [1:0] lo_v, hi_v;
    if (!impl_i) return '0;
    lo_v = (nonsec_i && !ns_mask_i[0]) ? 2'b00 : m_lo;
    hi_v = (nonsec_i && !ns_mask_i[1]) ? 2'b00 : m_hi;
    return {m_dis, 7'b0, hi_v, lo_v, 20'b0};
  endfunction

  function automatic logic exp_undef(input logic [1:0] el, input logic [1:0] cls);
    logic [1:0] eff;
    logic allow;
    if (!insn_valid_i || (cls != 2'd1 && cls != 2'd2) || el == 2'd2) return 1'b0;
    if (!impl_i) return 1'b1;
    eff = (nonsec_i && !ns_mask_i[0]) ? 2'b00 : m_lo;
    allow = (eff == 2'b11) || (eff == 2'b01 && el != 2'd0);
    return !allow || (cls == 2'd2 && m_dis);
  endfunction

  task automatic wr(input logic [1:0] el, input logic [31:0] d);
    @(negedge clk_i);
    el_i = el; sys_req_i = 1'b1; sys_we_i = 1'b1; sys_wdata_i = d;
    @(negedge clk_i);
    sys_req_i = 1'b0; sys_we_i = 1'b0;
    if (el != 2'd0 && impl_i) begin
      m_dis = d[31];
      if (!nonsec_i || ns_mask_i[0]) m_lo = d[21:20];
      if (!nonsec_i || ns_mask_i[1]) m_hi = d[23:22];
    end
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] el);
    @(negedge clk_i);
    el_i = el; sys_req_i = 1'b1; sys_we_i = 1'b0;
    #1;
    chk(tag, sys_rdata_o, (el == 2'd0) ? 32'h0 : exp_view());
    sys_req_i = 1'b0;
  endtask

  task automatic insn_chk(input string tag, input logic [1:0] el, input logic [1:0] cls);
    @(negedge clk_i);
    el_i = el; insn_valid_i = 1'b1; insn_class_i = cls;
    #1;
    chk(tag, {31'b0, insn_undef_o}, {31'b0, exp_undef(el, cls)});
    insn_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 reset read", 2'd1);
    insn_chk("R1 reset fp denied", 2'd1, 2'd1);
  endtask

  task automatic t_layout();
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk("R2 layout all ones", 2'd3);
    chk("R2 layout value", exp_view(), 32'h80F0_0000);
    wr(2'd3, 32'h0000_0000);
    rd_chk("R2 cleared", 2'd2);
  endtask

  task automatic t_tuple();
    @(negedge clk_i);
    el_i = 2'd1; sys_req_i = 1'b1; sys_we_i = 1'b1; sys_opc2_i = 3'd3; sys_wdata_i = 32'h00F0_0000;
    #1;
    chk("R3 miss hit_o", {31'b0, sys_hit_o}, 32'h0);
    @(negedge clk_i);
    sys_we_i = 1'b0;
    #1;
    chk("R3 miss rdata", sys_rdata_o, 32'h0);
    sys_req_i = 1'b0; sys_opc2_i = 3'd2;
    rd_chk("R3 state unchanged", 2'd1);
    @(negedge clk_i);
    sys_req_i = 1'b1; sys_crn_i = 4'd2;
    #1;
    chk("R3 crn miss", {31'b0, sys_hit_o}, 32'h0);
    sys_req_i = 1'b0; sys_crn_i = 4'd1;
  endtask

  task automatic t_el0();
    @(negedge clk_i);
    el_i = 2'd0; sys_req_i = 1'b1; sys_we_i = 1'b1; sys_wdata_i = 32'h80F0_0000;
    #1;
    chk("R4 el0 undef", {31'b0, sys_undef_o}, 32'h1);
    @(negedge clk_i);
    sys_we_i = 1'b0;
    #1;
    chk("R4 el0 read zero", sys_rdata_o, 32'h0);
    sys_req_i = 1'b0;
    rd_chk("R4 el0 no write", 2'd1);
    // write visible right after the capturing edge
    @(negedge clk_i);
    el_i = 2'd2; sys_req_i = 1'b1; sys_we_i = 1'b1; sys_wdata_i = 32'h0030_0000;
    #1;
    chk("R4 not yet written", {30'b0, m_lo}, 32'h0);
    @(negedge clk_i);
    sys_we_i = 1'b0; m_lo = 2'b11;
    #1;
    chk("R4 next edge", sys_rdata_o, 32'h0030_0000);
    sys_req_i = 1'b0;
  endtask

  task automatic t_enforce();
    for (int lo = 0; lo < 4; lo++) begin
      logic [1:0] l, h;
      l = lo[1:0];
      h = ~l;
      wr(2'd1, {8'b0, h, l, 20'b0});
      rd_chk("R6 high field readback", 2'd1);
      for (int e = 0; e < 4; e++) begin
        insn_chk((e == 2) ? "R8 el2 fp" : "R5 R6 fp", e[1:0], 2'd1);
        insn_chk((e == 2) ? "R8 el2 vec" : "R6 vec", e[1:0], 2'd2);
        insn_chk("R5 other class", e[1:0], 2'd0);
        insn_chk("R5 other class 3", e[1:0], 2'd3);
      end
    end
  endtask

  task automatic t_disable();
    wr(2'd1, 32'h8030_0000);
    insn_chk("R7 vec blocked el1", 2'd1, 2'd2);
    insn_chk("R7 vec blocked el3", 2'd3, 2'd2);
    insn_chk("R7 fp unaffected", 2'd1, 2'd1);
    insn_chk("R7 fp unaffected el0", 2'd0, 2'd1);
    insn_chk("R8 el2 vec with disable", 2'd2, 2'd2);
    wr(2'd1, 32'h0030_0000);
    insn_chk("R7 vec after clear", 2'd1, 2'd2);
  endtask

  task automatic t_nsmask();
    wr(2'd1, 32'h00F0_0000);
    nonsec_i = 1'b1; ns_mask_i = 2'b10;
    rd_chk("R9 low masked read", 2'd1);
    insn_chk("R9 low masked denied", 2'd1, 2'd1);
    wr(2'd1, 32'h0050_0000);
    rd_chk("R9 masked write ignored", 2'd1);
    ns_mask_i = 2'b01;
    rd_chk("R9 high masked read", 2'd1);
    wr(2'd1, 32'h0000_0000);
    ns_mask_i = 2'b11;
    rd_chk("R9 high kept after masked write", 2'd1);
    nonsec_i = 1'b0; ns_mask_i = 2'b00;
    rd_chk("R9 secure ignores mask", 2'd1);
    insn_chk("R9 secure enforcement", 2'd0, 2'd1);
    ns_mask_i = 2'b11;
  endtask

  task automatic t_absent();
    wr(2'd1, 32'h80F0_0000);
    impl_i = 1'b0;
    rd_chk("R10 absent read", 2'd1);
    insn_chk("R10 absent fp", 2'd3, 2'd1);
    insn_chk("R10 absent vec", 2'd1, 2'd2);
    insn_chk("R10 absent el2", 2'd2, 2'd1);
    wr(2'd1, 32'h0000_0000);
    impl_i = 1'b1;
    rd_chk("R10 write ignored while absent", 2'd1);
  endtask

  task automatic t_idle();
    wr(2'd1, 32'h0000_0000);
    @(negedge clk_i);
    el_i = 2'd0; insn_valid_i = 1'b0; insn_class_i = 2'd1;
    #1;
    chk("R11 invalid not flagged", {31'b0, insn_undef_o}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_layout();
    t_tuple();
    t_el0();
    t_enforce();
    t_disable();
    t_nsmask();
    t_absent();
    t_idle();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule